// File: doc/BRIEF.md
# Channel Event Interrupt Bank

This block gathers FIFO event pulses from ten capture channels and ten playback channels and turns them into one level interrupt for a processor. Each channel owns an 8-bit slot that holds six event kinds. Four slots are packed into each 32-bit word, so the ten channels fill three register groups. Every slot position has an enable bit. Every event leaves a sticky pending bit that software clears by writing ones. A masked view shows the pending bits that are also enabled.

A separate per-channel processor-enable word decides which channels may drive the interrupt line. Software reaches all words through a plain write strobe, a word address and write data. Read data follows the address in the same cycle.

Event input bit `ch*6 + e` carries event kind `e` of channel `ch`. Word addresses are as follows:

- 0 to 2: enable groups
- 3 to 5: clear groups
- 6 to 8: pending groups
- 9 to 11: masked groups
- 12: processor-enable word

Top module: `irq_event_bank`

## Requirements
- R1: After reset every enable bit, pending bit and processor-enable bit reads zero, and `irq_o` is low.
- R2: A one on event input bit `ch*6+e` sets bit `8*(ch mod 4)+e` of pending group `ch/4` (word address 6 + ch/4) at the next clock edge. The bit stays set until it is cleared.
- R3: Event kinds occupy slot bits 0 to 5 in this order: capture almost-empty, capture almost-full, playback almost-empty, playback almost-full, capture overflow, playback overflow.
- R4: Writing to clear group g (address 3+g) drops every pending bit of group g whose written bit is one. Written zeros leave pending bits unchanged.
- R5: When an event pulse and a clear of the same bit fall in one cycle, the bit ends up set.
- R6: Masked group g (address 9+g) reads as pending group g ANDed with enable group g (address g).
- R7: `irq_o` is high exactly when some channel has its processor-enable bit set and at least one of its masked bits set.
- R8: The processor-enable word (address 12) stores write data bits 0 to 9, one per channel. Bits 10 to 31 read zero.
- R9: Slot bits 6 and 7, and the unused slots 2 and 3 of the third group, read zero in the enable, pending and masked words. Writes to these bits are dropped.
- R10: Clear words read zero. Writes to pending or masked addresses change nothing.
- R11: Addresses 13 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 60 | Event pulses, bit ch*6+e |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_addr_i | input | 4 | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt level |

## Verification
The bench walks a single pulse through every channel and event kind. A wrong slot offset or group index shows up as a bit in the wrong word or the wrong position. A clear on the exact cycle of a new pulse must leave the bit set; a design that gives the clear priority would lose that event. The bench writes all ones to enable words, then reads them back, to catch stored padding bits. It writes to the pending and masked addresses to catch a design that treats them as writable. It also toggles the processor-enable and enable words separately, because a design that ignores either gate would raise the interrupt while it should stay low.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    typedef enum logic [2:0] {
        RK_ENABLE,
        RK_CLEAR,
        RK_RAW,
        RK_MASKED,
        RK_PROC,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] grp;
    } reg_sel_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_GRP = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int unsigned NG = NUM_GRP;

    always_comb begin
        int unsigned a;
        a = 32'(addr_i);
        sel_o.kind = RK_NONE;
        sel_o.grp  = '0;
        if (a < NG) begin
            sel_o.kind = RK_ENABLE;
            sel_o.grp  = 4'(a);
        end else if (a < 2 * NG) begin
            sel_o.kind = RK_CLEAR;
            sel_o.grp  = 4'(a - NG);
        end else if (a < 3 * NG) begin
            sel_o.kind = RK_RAW;
            sel_o.grp  = 4'(a - 2 * NG);
        end else if (a < 4 * NG) begin
            sel_o.kind = RK_MASKED;
            sel_o.grp  = 4'(a - 3 * NG);
        end else if (a == 4 * NG) begin
            sel_o.kind = RK_PROC;
        end
    end

endmodule

// File: rtl/irq_bank_chan.sv
module irq_bank_chan #(
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               en_we_i,
    input  logic [NUM_EVT-1:0] en_wd_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] raw_o,
    output logic [NUM_EVT-1:0] en_o
);

    // Pending bits are sticky; a new pulse beats a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_o <= '0;
            en_o  <= '0;
        end else begin
            raw_o <= evt_i | (raw_o & ~clr_i);
            if (en_we_i) begin
                en_o <= en_wd_i;
            end
        end
    end

endmodule

// File: rtl/irq_bank_reduce.sv
module irq_bank_reduce #(
    parameter int NUM_CH  = 10,
    parameter int NUM_EVT = 6
) (
    input  logic [NUM_CH*NUM_EVT-1:0] raw_i,
    input  logic [NUM_CH*NUM_EVT-1:0] en_i,
    input  logic [NUM_CH-1:0]         proc_en_i,
    output logic [NUM_CH*NUM_EVT-1:0] msk_o,
    output logic                      irq_o
);
    logic [NUM_CH-1:0] ch_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign msk_o[c*NUM_EVT +: NUM_EVT] = raw_i[c*NUM_EVT +: NUM_EVT] & en_i[c*NUM_EVT +: NUM_EVT];
        assign ch_hit[c] = proc_en_i[c] & (|msk_o[c*NUM_EVT +: NUM_EVT]);
    end

    assign irq_o = |ch_hit;

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_CH  = 10,
    parameter int NUM_EVT = 6,
    parameter int SLOT_W  = 8,
    parameter int SLOTS   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_EVT-1:0] evt_pulse_i,
    input  logic                      reg_wr_i,
    input  logic [ADDR_W-1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]         reg_wdata_i,
    output logic [DATA_W-1:0]         reg_rdata_o,
    output logic                      irq_o
);
    localparam int NUM_GRP = (NUM_CH + SLOTS - 1) / SLOTS;
    localparam int FLAT_W  = NUM_CH * NUM_EVT;

    reg_sel_t            sel;
    logic [FLAT_W-1:0]   raw_flat;
    logic [FLAT_W-1:0]   en_flat;
    logic [FLAT_W-1:0]   clr_flat;
    logic [FLAT_W-1:0]   msk_flat;
    logic [NUM_CH-1:0]   proc_en;
    logic [DATA_W-1:0]   en_grp  [NUM_GRP];
    logic [DATA_W-1:0]   raw_grp [NUM_GRP];
    logic [DATA_W-1:0]   msk_grp [NUM_GRP];

    irq_bank_decode #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)) u_dec (
        .addr_i (reg_addr_i),
        .sel_o  (sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int G = c / SLOTS;
        localparam int S = c % SLOTS;
        logic grp_hit;
        logic en_we;

        assign grp_hit = (int'(sel.grp) == G);
        assign en_we   = reg_wr_i && (sel.kind == RK_ENABLE) && grp_hit;
        assign clr_flat[c*NUM_EVT +: NUM_EVT] =
            (reg_wr_i && (sel.kind == RK_CLEAR) && grp_hit) ?
            reg_wdata_i[S*SLOT_W +: NUM_EVT] : '0;

        irq_bank_chan #(.NUM_EVT(NUM_EVT)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_pulse_i[c*NUM_EVT +: NUM_EVT]),
            .en_we_i (en_we),
            .en_wd_i (reg_wdata_i[S*SLOT_W +: NUM_EVT]),
            .clr_i   (clr_flat[c*NUM_EVT +: NUM_EVT]),
            .raw_o   (raw_flat[c*NUM_EVT +: NUM_EVT]),
            .en_o    (en_flat[c*NUM_EVT +: NUM_EVT])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proc_en <= '0;
        end else if (reg_wr_i && (sel.kind == RK_PROC)) begin
            proc_en <= reg_wdata_i[NUM_CH-1:0];
        end
    end

    irq_bank_reduce #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT)) u_red (
        .raw_i     (raw_flat),
        .en_i      (en_flat),
        .proc_en_i (proc_en),
        .msk_o     (msk_flat),
        .irq_o     (irq_o)
    );

    // Pack channel slots into group words; padding stays zero.
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            en_grp[g]  = '0;
            raw_grp[g] = '0;
            msk_grp[g] = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (g * SLOTS + s < NUM_CH) begin
                    en_grp[g][s*SLOT_W +: NUM_EVT]  = en_flat[(g*SLOTS+s)*NUM_EVT +: NUM_EVT];
                    raw_grp[g][s*SLOT_W +: NUM_EVT] = raw_flat[(g*SLOTS+s)*NUM_EVT +: NUM_EVT];
                    msk_grp[g][s*SLOT_W +: NUM_EVT] = msk_flat[(g*SLOTS+s)*NUM_EVT +: NUM_EVT];
                end
            end
        end
    end

    always_comb begin
        int gi;
        gi = int'(sel.grp);
        reg_rdata_o = '0;
        unique case (sel.kind)
            RK_ENABLE: if (gi < NUM_GRP) reg_rdata_o = en_grp[gi];
            RK_RAW:    if (gi < NUM_GRP) reg_rdata_o = raw_grp[gi];
            RK_MASKED: if (gi < NUM_GRP) reg_rdata_o = msk_grp[gi];
            RK_PROC:   reg_rdata_o = {{(DATA_W-NUM_CH){1'b0}}, proc_en};
            RK_CLEAR, RK_NONE: reg_rdata_o = '0;
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_event_bank_chk.sv
module irq_event_bank_chk #(
    parameter int NUM_CH  = 10,
    parameter int NUM_EVT = 6,
    parameter int SLOT_W  = 8,
    parameter int SLOTS   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH*NUM_EVT-1:0] evt_pulse_i,
    input logic [NUM_CH*NUM_EVT-1:0] raw_flat,
    input logic [NUM_CH*NUM_EVT-1:0] en_flat,
    input logic [NUM_CH*NUM_EVT-1:0] clr_flat,
    input logic [NUM_CH-1:0]         proc_en,
    input logic [ADDR_W-1:0]         reg_addr_i,
    input logic [DATA_W-1:0]         reg_rdata_o,
    input logic                      irq_o
);
    localparam int NUM_GRP   = (NUM_CH + SLOTS - 1) / SLOTS;
    localparam int LAST_BITS = ((NUM_CH - 1) % SLOTS + 1) * SLOT_W;

    function automatic logic [DATA_W-1:0] pad_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int s = 0; s < SLOTS; s++)
            for (int b = NUM_EVT; b < SLOT_W; b++)
                m[s*SLOT_W + b] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] PAD = pad_mask();

    // R2 / R5: every pulsed bit is pending one cycle later, clear or not
    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse_i) |=> ((raw_flat & $past(evt_pulse_i)) == $past(evt_pulse_i)));

    // R5: pulse and clear together leave the bit set
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse_i & clr_flat)) |=>
        ((raw_flat & $past(evt_pulse_i & clr_flat)) == $past(evt_pulse_i & clr_flat)));

    // R4: pending bits outside the clear mask are kept
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_flat & ~clr_flat)) |=>
        ((raw_flat & $past(raw_flat & ~clr_flat)) == $past(raw_flat & ~clr_flat)));

    // R7: no processor-enabled channel, no interrupt
    p_proc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_en == '0) |-> !irq_o);

    // R6 / R7: nothing both pending and enabled, no interrupt
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_flat & en_flat) == '0) |-> !irq_o);

    // R9: padding bits of group words read zero
    p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(reg_addr_i) < 4 * NUM_GRP) |-> ((reg_rdata_o & PAD) == '0));

    // R9: unused slots of the last group read zero
    p_last_grp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(reg_addr_i) == NUM_GRP - 1) || (32'(reg_addr_i) == 3 * NUM_GRP - 1) ||
         (32'(reg_addr_i) == 4 * NUM_GRP - 1)) |-> ((reg_rdata_o >> LAST_BITS) == '0));

    // R11: addresses above the map read zero
    p_hole_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(reg_addr_i) > 4 * NUM_GRP) |-> (reg_rdata_o == '0));

endmodule

bind irq_event_bank irq_event_bank_chk #(
    .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .SLOT_W(SLOT_W),
    .SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse_i (evt_pulse_i),
    .raw_flat    (raw_flat),
    .en_flat     (en_flat),
    .clr_flat    (clr_flat),
    .proc_en     (proc_en),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
);

// File: tb/tb_irq_event_bank.sv
`timescale 1ns/1ps
module tb_irq_event_bank;
    localparam int NCH = 10;
    localparam int NEV = 6;
    localparam int FW  = NCH * NEV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] evt = '0;
    logic          wr = 1'b0;
    logic [3:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model, built from the requirements
    logic [FW-1:0]  m_raw = '0;
    logic [FW-1:0]  m_en  = '0;
    logic [NCH-1:0] m_pe  = '0;

    typedef struct {
        int          a;      // -1 means the irq line
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #2 clk = ~clk;

    irq_event_bank dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [FW-1:0] ebit(int ch, int e);
        return FW'(1) << (ch * NEV + e);
    endfunction

    function automatic logic [31:0] pack(logic [FW-1:0] v, int g);
        logic [31:0] r = '0;
        for (int s = 0; s < 4; s++)
            if (g * 4 + s < NCH)
                for (int e = 0; e < NEV; e++) r[s*8+e] = v[(g*4+s)*NEV+e];
        return r;
    endfunction

    function automatic logic [FW-1:0] unpack(logic [31:0] d, int g);
        logic [FW-1:0] r = '0;
        for (int s = 0; s < 4; s++)
            if (g * 4 + s < NCH)
                for (int e = 0; e < NEV; e++) r[(g*4+s)*NEV+e] = d[s*8+e];
        return r;
    endfunction

    function automatic logic [31:0] m_read(int a);
        if (a < 3)  return pack(m_en, a);
        if (a < 6)  return '0;
        if (a < 9)  return pack(m_raw, a - 6);
        if (a < 12) return pack(m_raw & m_en, a - 9);
        if (a == 12) return {22'd0, m_pe};
        return '0;
    endfunction

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int c = 0; c < NCH; c++)
            if (m_pe[c] && |(m_raw[c*NEV +: NEV] & m_en[c*NEV +: NEV])) r = 1'b1;
        return r;
    endfunction

    // driver: one cycle of stimulus, model updated at the edge
    task automatic step(logic [FW-1:0] ev, bit w, int a, logic [31:0] d);
        logic [FW-1:0] clr = '0;
        @(negedge clk);
        evt = ev; wr = w; addr = 4'(a); wdata = d;
        @(posedge clk);
        if (w && a >= 3 && a < 6) clr = unpack(d, a - 3);
        if (w && a < 3) m_en = (m_en & ~unpack('1, a)) | unpack(d, a);
        if (w && a == 12) m_pe = d[NCH-1:0];
        m_raw = ev | (m_raw & ~clr);
        #1;
        evt = '0; wr = 1'b0;
    endtask

    task automatic chk_rd(int a, string tag);
        item_t it;
        @(negedge clk);
        addr = 4'(a);
        it.a = a; it.exp = m_read(a); it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic chk_irq(string tag);
        item_t it;
        @(negedge clk);
        it.a = -1; it.exp = {31'd0, m_irq()}; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    // monitor: pops the expected item and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(mon_ev);
            #0.5;
            it = sb_q.pop_front();
            act = (it.a < 0) ? {31'd0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state, R11 holes
        for (int a = 0; a < 16; a++) chk_rd(a, (a > 12) ? "R11 hole" : "R1 reset");
        chk_irq("R1 irq after reset");

        // R2 R3 placement of every channel/event, R4 clear by writing one
        for (int c = 0; c < NCH; c++) begin
            for (int e = 0; e < NEV; e++) begin
                step(ebit(c, e), 0, 0, '0);
                chk_rd(6 + c / 4, "R2 R3 placement");
                step('0, 1, 3 + c / 4, 32'(1) << ((c % 4) * 8 + e));
                chk_rd(6 + c / 4, "R4 cleared");
            end
        end

        // R2 sticky over idle cycles
        step(ebit(0, 0) | ebit(5, 3) | ebit(9, 5), 0, 0, '0);
        for (int a = 6; a < 9; a++) chk_rd(a, "R2 set");
        repeat (3) step('0, 0, 0, '0);
        for (int a = 6; a < 9; a++) chk_rd(a, "R2 sticky");

        // R9 padding dropped, R6 masking, R7 gate
        step('0, 1, 1, 32'hFFFF_FFFF);
        chk_rd(1, "R9 enable padding");
        step('0, 1, 2, 32'hFFFF_FFFF);
        chk_rd(2, "R9 enable unused slots");
        chk_rd(10, "R6 masked grp1");
        chk_rd(9, "R6 masked grp0 disabled");
        chk_rd(11, "R6 masked grp2");
        chk_irq("R7 no processor enable");

        // R8 processor-enable width
        step('0, 1, 12, 32'hFFFF_FFFF);
        chk_rd(12, "R8 proc enable bits");
        chk_irq("R7 irq raised");
        step('0, 1, 12, 32'h1);
        chk_irq("R7 only ch0 gated, not enabled");
        step('0, 1, 0, 32'h1);
        chk_irq("R7 ch0 enabled");
        chk_rd(9, "R6 masked ch0");

        // R4 zeros have no effect, ones clear
        step('0, 1, 3, 32'h0);
        chk_rd(6, "R4 zero write keeps");
        step('0, 1, 3, 32'h1);
        chk_rd(6, "R4 one write clears");
        chk_irq("R7 irq drops after clear");

        // R5 event beats clear in the same cycle
        step(ebit(9, 5), 1, 5, 32'(1) << 13);
        chk_rd(8, "R5 event wins");
        step('0, 1, 5, 32'(1) << 13);
        chk_rd(8, "R4 clear after R5");

        // R10 read-only and clear-read behaviour
        step('0, 1, 7, 32'hFFFF_FFFF);
        chk_rd(7, "R10 pending write ignored");
        step('0, 1, 10, 32'h0);
        chk_rd(10, "R10 masked write ignored");
        chk_rd(4, "R10 clear reads zero");
        step('0, 1, 14, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) chk_rd(a, "R11 map after hole write");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule